// File: doc/BRIEF.md
# 8-to-14-bit Sample Gearbox

This block sits behind a serial input deserializer that delivers 8-bit words and turns that byte stream into 14-bit converter samples. Each accepted word is appended to a bit accumulator that tracks how many bits it holds. When at least 14 bits are present, one sample is released and the remaining bits stay in the accumulator for the next sample. Because 14 is not a multiple of 8, samples arrive unevenly: sometimes two input words apart, sometimes only one. Over seven input words the block produces exactly four samples.

The sender may transmit each word least-significant bit first or most-significant bit first, and a select input chooses which. Word alignment is found by a separate aligner. That aligner gives this block a bit offset, and the block drops that many leading bits of the stream after reset so that the first sample starts on a true sample boundary.

Top module: `sample_gearbox`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `smp_vld` is 0. Reset empties the accumulator, and `start_ofs` is captured while `rst` is high.
- R2: With `msb_first` = 0, bit i of `in_data` is the i-th bit in time. Bit k of each sample is the k-th retained bit in time, so the sample LSB is the earliest bit.
- R3: With `msb_first` = 1, bit 7 of `in_data` is the earliest bit in time. Bit 13 of each sample is the earliest retained bit, and bit 0 is the latest.
- R4: With one word accepted per cycle and an offset of 0, samples complete on input words 2, 4, 6 and 7 of every group of seven. Across a run of W words, the block emits floor((8W − offset)/14) samples.
- R5: Leftover bits carry into the next sample. Sample j holds retained stream bits 14j to 14j+13, and no bit is lost or repeated.
- R6: After reset, the first `start_ofs` bits of the stream are discarded. Any offset from 0 to 15 is allowed, so the discard may span two input words.
- R7: A cycle with `in_vld` low changes nothing, whatever is on `in_data`, and it produces no sample.
- R8: `smp_vld` is a registered one-cycle pulse per sample. It is raised in the cycle after the clock edge that accepts the word completing the sample, and `smp_data` holds the sample while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Word from the deserializer |
| in_vld | input | 1 | Qualifies `in_data` for this cycle |
| msb_first | input | 1 | 0: words arrive LSB first, 1: MSB first |
| start_ofs | input | 4 | Number of leading stream bits to discard after reset |
| smp_data | output | 14 | Repacked sample |
| smp_vld | output | 1 | One-cycle strobe qualifying `smp_data` |

## Verification
The bench builds the block with its default sizes: 8-bit words, 14-bit samples and a 4-bit offset. The offset field is small enough to sweep all sixteen values under both bit orders, both with and without idle gaps. Every 70-word run therefore covers ten full cadence periods, discards that cross a word edge, and leftover counts from 0 to 7. The expected cadence, sample count and sample contents all come from floor arithmetic on the bit index.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  typedef enum logic {
    ORD_LSB = 1'b0,
    ORD_MSB = 1'b1
  } bit_order_e;

endpackage

// File: rtl/gbx_bit_order.sv
// Converts between wire order and time order (bit 0 = earliest).
module gbx_bit_order
  import gbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_i,
  input  bit_order_e   order_i,
  output logic [W-1:0] bits_o
);

  logic [W-1:0] reversed;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign reversed[i] = bits_i[W-1-i];
  end

  assign bits_o = (order_i == ORD_MSB) ? reversed : bits_i;

endmodule

// File: rtl/gbx_skip.sv
// Discards a programmable number of leading stream bits after reset.
module gbx_skip #(
  parameter int IN_W  = 8,
  parameter int OFS_W = 4,
  localparam int CW   = $clog2(IN_W + 1),
  localparam int DW   = (OFS_W > CW) ? OFS_W : CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             vld_i,
  input  logic [IN_W-1:0]  bits_i,
  output logic [IN_W-1:0]  bits_o,
  output logic [CW-1:0]    cnt_o
);

  logic [OFS_W-1:0] drop_q;
  logic [DW-1:0]    drop_ext;
  logic [DW-1:0]    take;

  always_comb begin
    drop_ext = DW'(drop_q);
    if (drop_ext > DW'(IN_W)) begin
      take = DW'(IN_W);
    end else begin
      take = drop_ext;
    end
    bits_o = bits_i >> take;
    cnt_o  = CW'(IN_W) - CW'(take);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= ofs_i;
    end else if (vld_i) begin
      drop_q <= drop_q - OFS_W'(take);
    end
  end

endmodule

// File: rtl/gbx_accum.sv
// Bit accumulator with fill count; releases OUT_W bits when enough are held.
module gbx_accum #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 14,
  localparam int CW    = $clog2(IN_W + 1),
  localparam int ACC_W = IN_W + OUT_W - 1,
  localparam int FW    = $clog2(ACC_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [IN_W-1:0]  bits_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [OUT_W-1:0] word_o,
  output logic             emit_o,
  output logic [FW-1:0]    fill_o
);

  logic [ACC_W-1:0] acc_q;
  logic [FW-1:0]    fill_q;
  logic [ACC_W-1:0] merged;
  logic [FW-1:0]    fill_sum;

  always_comb begin
    merged   = acc_q | (ACC_W'(bits_i) << fill_q);
    fill_sum = fill_q + FW'(cnt_i);
    emit_o   = vld_i && (fill_sum >= FW'(OUT_W));
    word_o   = merged[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (vld_i) begin
      if (emit_o) begin
        acc_q  <= merged >> OUT_W;
        fill_q <= fill_sum - FW'(OUT_W);
      end else begin
        acc_q  <= merged;
        fill_q <= fill_sum;
      end
    end
  end

  assign fill_o = fill_q;

endmodule

// File: rtl/sample_gearbox.sv
module sample_gearbox
  import gbx_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 14,
  parameter int OFS_W = 4,
  localparam int CW    = $clog2(IN_W + 1),
  localparam int ACC_W = IN_W + OUT_W - 1,
  localparam int FW    = $clog2(ACC_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_vld,
  input  logic             msb_first,
  input  logic [OFS_W-1:0] start_ofs,
  output logic [OUT_W-1:0] smp_data,
  output logic             smp_vld
);

  bit_order_e       order;
  logic [IN_W-1:0]  time_bits;
  logic [IN_W-1:0]  kept_bits;
  logic [CW-1:0]    kept_cnt;
  logic [OUT_W-1:0] time_word;
  logic [OUT_W-1:0] wire_word;
  logic             emit;
  logic [FW-1:0]    acc_fill;

  assign order = bit_order_e'(msb_first);

  gbx_bit_order #(.W(IN_W)) i_order_in (
    .bits_i  (in_data),
    .order_i (order),
    .bits_o  (time_bits)
  );

  gbx_skip #(.IN_W(IN_W), .OFS_W(OFS_W)) i_skip (
    .clk    (clk),
    .rst    (rst),
    .ofs_i  (start_ofs),
    .vld_i  (in_vld),
    .bits_i (time_bits),
    .bits_o (kept_bits),
    .cnt_o  (kept_cnt)
  );

  gbx_accum #(.IN_W(IN_W), .OUT_W(OUT_W)) i_accum (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (in_vld),
    .bits_i (kept_bits),
    .cnt_i  (kept_cnt),
    .word_o (time_word),
    .emit_o (emit),
    .fill_o (acc_fill)
  );

  gbx_bit_order #(.W(OUT_W)) i_order_out (
    .bits_i  (time_word),
    .order_i (order),
    .bits_o  (wire_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_vld  <= 1'b0;
      smp_data <= '0;
    end else begin
      smp_vld <= emit;
      if (emit) begin
        smp_data <= wire_word;
      end
    end
  end

endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 14,
  localparam int ACC_W = IN_W + OUT_W - 1,
  localparam int FW    = $clog2(ACC_W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          smp_vld,
  input logic [FW-1:0] fill
);

  // R8: a sample strobe is always caused by a word accepted one edge earlier
  assert_vld_follows_input_R8: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(in_vld));

  // R1: no sample on the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !smp_vld);

  // R5: the accumulator never holds more than it can carry
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(ACC_W));

  // R5: after a release, fewer than one word of bits remains
  assert_leftover_small_R5: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> (fill < FW'(IN_W)));

  // R7: an idle cycle leaves the fill unchanged and releases nothing
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_vld) && !$past(rst)) |-> ($stable(fill) && !smp_vld));

endmodule

bind sample_gearbox gbx_checker i_gbx_checker (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .smp_vld (smp_vld),
  .fill    (acc_fill)
);

// File: tb/test_sample_gearbox.sv
module test_sample_gearbox;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 8;
  localparam int OUT_W      = 14;
  localparam int OFS_W      = 4;
  localparam int NWORDS     = 70;

  logic             clk = 1'b0;
  logic             rst;
  logic [IN_W-1:0]  in_data;
  logic             in_vld;
  logic             msb_first;
  logic [OFS_W-1:0] start_ofs;
  logic [OUT_W-1:0] smp_data;
  logic             smp_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit stream [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_gearbox i_sample_gearbox (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_vld    (in_vld),
    .msb_first (msb_first),
    .start_ofs (start_ofs),
    .smp_data  (smp_data),
    .smp_vld   (smp_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int samples_after(input int w, input int ofs);
    int bits = 8 * w - ofs;
    return (bits < 0) ? 0 : bits / OUT_W;
  endfunction

  function automatic int expected_sample(input int j, input int ofs, input int ord);
    int e = 0;
    for (int k = 0; k < OUT_W; k++) begin
      if (stream[ofs + OUT_W*j + k]) begin
        if (ord == 0) e |= (1 << k);
        else          e |= (1 << (OUT_W - 1 - k));
      end
    end
    return e;
  endfunction

  task automatic run(input int ord, input int ofs, input int gap);
    int got = 0;
    rst       = 1'b1;
    in_vld    = 1'b0;
    in_data   = 8'hA5;
    msb_first = ord[0];
    start_ofs = OFS_W'(ofs);
    repeat (3) @(negedge clk);
    check(smp_vld == 1'b0, "R1 strobe in reset", int'(smp_vld), 0);
    rst = 1'b0;
    for (int w = 1; w <= NWORDS; w++) begin
      logic [7:0] b;
      b = 8'((w * 73 + ofs * 29 + ord * 101 + gap * 7 + 60) & 255);
      for (int i = 0; i < IN_W; i++) begin
        stream[(w - 1) * IN_W + i] = (ord == 0) ? b[i] : b[IN_W - 1 - i];
      end
      in_data = b;
      in_vld  = 1'b1;
      @(negedge clk);
      begin
        bit exp_v;
        exp_v = samples_after(w, ofs) > samples_after(w - 1, ofs);
        check(smp_vld == exp_v, "R4 R8 cadence", int'(smp_vld), int'(exp_v));
        if (smp_vld && exp_v) begin
          int e;
          string req;
          e = expected_sample(got, ofs, ord);
          if (got > 0)       req = "R5 carry";
          else if (ofs != 0) req = "R6 offset";
          else if (ord == 0) req = "R2 lsb order";
          else               req = "R3 msb order";
          check(int'(smp_data) == e, req, int'(smp_data), e);
        end
        if (smp_vld) got++;
      end
      if (gap != 0 && (w % 3) == 0) begin
        in_vld  = 1'b0;
        in_data = ~b;
        @(negedge clk);
        check(smp_vld == 1'b0, "R7 idle cycle", int'(smp_vld), 0);
      end
    end
    in_vld = 1'b0;
    @(negedge clk);
    check(smp_vld == 1'b0, "R7 idle tail", int'(smp_vld), 0);
    check(got == samples_after(NWORDS, ofs), "R4 sample count", got, samples_after(NWORDS, ofs));
  endtask

  initial begin
    rst       = 1'b1;
    in_vld    = 1'b0;
    in_data   = '0;
    msb_first = 1'b0;
    start_ofs = '0;
    @(negedge clk);
    for (int ord = 0; ord < 2; ord++) begin
      for (int gap = 0; gap < 2; gap++) begin
        for (int ofs = 0; ofs < 16; ofs++) begin
          run(ord, ofs, gap);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule